// File: doc/BRIEF.md
# Development Mode Entry Controller

This block decides, once per power cycle, whether a supply supervisor runs in its development mode. In that mode the watchdog is stopped and the CAN transceiver and the secondary supply default to on. When power-on reset is released the block opens a monitoring window and watches a test pin while the supervisor is in its init mode. The choice is made when the first SPI command arrives during init with the pin low. A high level on the pin that lasts a filtered number of ticks closes the window for good. Leaving init by any other route also closes the window for good.

Once development mode is entered, no mode change and no pin activity can clear it. Only a new power-on reset clears it. The block also combines the fail-safe requests. Watchdog failures are masked while development mode is active. Every other failure cause always passes through.

Top module: `dev_entry_ctrl`

## Requirements
- R1: After power-on reset is released, the window is open: dev_mode=0, wd_disable=0, can_dflt_on=1, vcc2_dflt_on=1 and safe_req=0.
- R2: A one-cycle spi_cmd pulse while init_mode=1 and test_pin=0, with the window open, sets dev_mode=1 on the next clock edge.
- R3: If test_pin stays high through T_TEST tick pulses (default 8) while the window is open, the window closes. After that, an SPI command with the pin low does not enter development mode.
- R4: If test_pin is high for fewer than T_TEST ticks, the pulse is ignored. Any cycle with the pin low restarts the count, so several short pulses whose total exceeds T_TEST do not close the window.
- R5: An SPI command received during init while test_pin=1 closes the window without entering development mode.
- R6: If init_mode drops while the window is open and no SPI command arrives, the window closes. It does not re-open until the next power-on reset.
- R7: Once dev_mode=1, it stays 1 whatever init_mode, test_pin, spi_cmd or tick do.
- R8: wd_disable equals dev_mode. While dev_mode=1, wd_fail does not raise safe_req. While dev_mode=0, wd_fail raises safe_req in the same cycle.
- R9: other_fail raises safe_req in the same cycle in every state.
- R10: can_dflt_on and vcc2_dflt_on are 1 while the window is open and in development mode. They are 0 once the window has closed without entry.
- R11: Asserting power-on reset clears development mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| init_mode | input | 1 | High while the supervisor is in its init mode |
| test_pin | input | 1 | Test pin level (synchronous) |
| spi_cmd | input | 1 | One-cycle strobe per SPI command received |
| tick | input | 1 | One-cycle strobe for the high-time filter |
| wd_fail | input | 1 | Watchdog failure event |
| other_fail | input | 1 | Any non-watchdog fail-safe cause |
| dev_mode | output | 1 | Development mode active |
| wd_disable | output | 1 | Stops the watchdog |
| can_dflt_on | output | 1 | CAN default-on enable |
| vcc2_dflt_on | output | 1 | Secondary supply default-on enable |
| safe_req | output | 1 | Combined fail-safe or restart request |

## Verification
Several behaviours hold on every cycle and are checked by the assertions. Development mode and a closed window are both terminal states. The filter count never passes its limit and is cleared in any cycle with the pin low. A watchdog failure never leaks through in development mode, and other failures always reach safe_req. Other behaviours depend on a sequence of events, and only the bench scenarios show them. These are the commit by an SPI command, the abort after exactly T_TEST high ticks, the rejection of broken-up short pulses, and the closing of the window by an SPI command with the pin high or by leaving init early.

// File: rtl/devmode_pkg.sv
package devmode_pkg;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_USER  = 2'd1,
        ST_DEV   = 2'd2
    } dm_state_e;

    typedef struct packed {
        dm_state_e state;
    } dm_fsm_regs_t;

endpackage

// File: rtl/devmode_hifilt.sv
module devmode_hifilt #(
    parameter int T_TEST = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pin,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(T_TEST + 1);
    localparam logic [CW-1:0] LIMIT = CW'(T_TEST);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } filt_regs_t;

    filt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!en || !pin) begin
            r_d.cnt = '0;
        end else if (tick && (r_q.cnt != LIMIT)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign expired = en && (r_q.cnt == LIMIT);

    // R4: the counter saturates at its limit
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LIMIT);

    // R4: a low pin restarts the high-time count
    assert_low_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin) |=> (r_q.cnt == '0));

endmodule

// File: rtl/devmode_fsm.sv
module devmode_fsm
    import devmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      init_mode,
    input  logic      test_pin,
    input  logic      spi_cmd,
    input  logic      expired,
    output dm_state_e state
);
    dm_fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_ARMED: begin
                if (expired) begin
                    r_d.state = ST_USER;
                end else if (spi_cmd && init_mode) begin
                    r_d.state = test_pin ? ST_USER : ST_DEV;
                end else if (!init_mode) begin
                    r_d.state = ST_USER;
                end
            end
            ST_USER: r_d.state = ST_USER;
            ST_DEV:  r_d.state = ST_DEV;
            default: r_d.state = ST_USER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_ARMED;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.state;

    // R7: development mode is held until power-on reset
    assert_dev_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DEV) |=> (r_q.state == ST_DEV));

    // R6: a closed window never re-opens
    assert_no_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_USER) |=> (r_q.state == ST_USER));

    // R3: an expired filter blocks entry
    assert_abort_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ARMED && expired) |=> (r_q.state == ST_USER));

    // R5: command with pin high never commits
    assert_high_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ARMED && spi_cmd && test_pin) |=> (r_q.state != ST_DEV));

endmodule

// File: rtl/dev_entry_ctrl.sv
module dev_entry_ctrl
    import devmode_pkg::*;
#(
    parameter int T_TEST = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic init_mode,
    input  logic test_pin,
    input  logic spi_cmd,
    input  logic tick,
    input  logic wd_fail,
    input  logic other_fail,
    output logic dev_mode,
    output logic wd_disable,
    output logic can_dflt_on,
    output logic vcc2_dflt_on,
    output logic safe_req
);
    dm_state_e state;
    logic      expired;
    logic      armed;

    assign armed = (state == ST_ARMED);

    devmode_hifilt #(.T_TEST(T_TEST)) u_filt (
        .clk     (clk),
        .rst_n   (por_n),
        .en      (armed),
        .pin     (test_pin),
        .tick    (tick),
        .expired (expired)
    );

    devmode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (por_n),
        .init_mode (init_mode),
        .test_pin  (test_pin),
        .spi_cmd   (spi_cmd),
        .expired   (expired),
        .state     (state)
    );

    assign dev_mode     = (state == ST_DEV);
    assign wd_disable   = dev_mode;
    assign can_dflt_on  = dev_mode || armed;
    assign vcc2_dflt_on = dev_mode || armed;
    assign safe_req     = other_fail || (wd_fail && !dev_mode);

    // R8: watchdog failures are masked in development mode
    assert_wd_masked_R8: assert property (@(posedge clk) disable iff (!por_n)
        (dev_mode && !other_fail) |-> !safe_req);

    // R9: other causes always reach the request
    assert_other_pass_R9: assert property (@(posedge clk) disable iff (!por_n)
        other_fail |-> safe_req);

    // R10: defaults drop once the window has closed without entry
    assert_dflt_off_R10: assert property (@(posedge clk) disable iff (!por_n)
        (!dev_mode && $past(!armed)) |-> (!can_dflt_on && !vcc2_dflt_on));

endmodule

// File: tb/sim_dev_entry_ctrl.sv
module sim_dev_entry_ctrl;
    localparam int T_TEST = 8;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic init_mode = 1'b1;
    logic test_pin = 1'b0;
    logic spi_cmd = 1'b0;
    logic tick = 1'b0;
    logic wd_fail = 1'b0;
    logic other_fail = 1'b0;
    logic dev_mode, wd_disable, can_dflt_on, vcc2_dflt_on, safe_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dev_entry_ctrl #(.T_TEST(T_TEST)) u0 (
        .clk(clk), .por_n(por_n), .init_mode(init_mode), .test_pin(test_pin),
        .spi_cmd(spi_cmd), .tick(tick), .wd_fail(wd_fail), .other_fail(other_fail),
        .dev_mode(dev_mode), .wd_disable(wd_disable), .can_dflt_on(can_dflt_on),
        .vcc2_dflt_on(vcc2_dflt_on), .safe_req(safe_req)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_por();
        @(negedge clk);
        por_n = 1'b0; init_mode = 1'b1; test_pin = 1'b0; spi_cmd = 1'b0;
        tick = 1'b0; wd_fail = 1'b0; other_fail = 1'b0;
        cyc(3);
        por_n = 1'b1;
        cyc(1);
    endtask

    task automatic send_spi();
        spi_cmd = 1'b1;
        cyc(1);
        spi_cmd = 1'b0;
        cyc(1);
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc(1);
            tick = 1'b0;
            cyc(1);
        end
    endtask

    task automatic t_reset_state();
        do_por();
        chk("R1", "dev_mode", dev_mode, 1'b0);
        chk("R1", "wd_disable", wd_disable, 1'b0);
        chk("R1", "can_dflt_on", can_dflt_on, 1'b1);
        chk("R1", "vcc2_dflt_on", vcc2_dflt_on, 1'b1);
        chk("R1", "safe_req", safe_req, 1'b0);
    endtask

    task automatic t_commit_and_hold();
        do_por();
        send_spi();
        chk("R2", "dev_mode after commit", dev_mode, 1'b1);
        chk("R8", "wd_disable in dev", wd_disable, 1'b1);
        init_mode = 1'b0; test_pin = 1'b1;
        give_ticks(T_TEST + 2);
        send_spi();
        chk("R7", "dev_mode held", dev_mode, 1'b1);
        chk("R10", "can_dflt_on in dev", can_dflt_on, 1'b1);
        chk("R10", "vcc2_dflt_on in dev", vcc2_dflt_on, 1'b1);
        wd_fail = 1'b1; #1;
        chk("R8", "wd_fail masked", safe_req, 1'b0);
        other_fail = 1'b1; #1;
        chk("R9", "other_fail in dev", safe_req, 1'b1);
        wd_fail = 1'b0; other_fail = 1'b0;
        cyc(1);
        por_n = 1'b0; #1;
        chk("R11", "por clears dev", dev_mode, 1'b0);
        cyc(1);
        por_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_abort();
        do_por();
        test_pin = 1'b1;
        give_ticks(T_TEST - 1);
        chk("R3", "window open one tick before limit", can_dflt_on, 1'b1);
        give_ticks(1);
        cyc(1);
        chk("R3", "window closed at limit", can_dflt_on, 1'b0);
        chk("R10", "vcc2_dflt_on off after abort", vcc2_dflt_on, 1'b0);
        test_pin = 1'b0;
        cyc(1);
        send_spi();
        chk("R3", "no entry after abort", dev_mode, 1'b0);
        wd_fail = 1'b1; #1;
        chk("R8", "wd_fail passes in user", safe_req, 1'b1);
        wd_fail = 1'b0;
        other_fail = 1'b1; #1;
        chk("R9", "other_fail in user", safe_req, 1'b1);
        other_fail = 1'b0;
    endtask

    task automatic t_short_pulses();
        do_por();
        test_pin = 1'b1;
        give_ticks(T_TEST - 1);
        test_pin = 1'b0;
        cyc(2);
        test_pin = 1'b1;
        give_ticks(T_TEST - 1);
        test_pin = 1'b0;
        cyc(1);
        chk("R4", "window still open", can_dflt_on, 1'b1);
        send_spi();
        chk("R4", "entry after short pulses", dev_mode, 1'b1);
    endtask

    task automatic t_cmd_pin_high();
        do_por();
        test_pin = 1'b1;
        send_spi();
        chk("R5", "no entry with pin high", dev_mode, 1'b0);
        chk("R5", "window closed", can_dflt_on, 1'b0);
        test_pin = 1'b0;
        send_spi();
        chk("R5", "later command ignored", dev_mode, 1'b0);
    endtask

    task automatic t_init_left();
        do_por();
        init_mode = 1'b0;
        cyc(1);
        init_mode = 1'b1;
        cyc(1);
        chk("R6", "window closed on init exit", can_dflt_on, 1'b0);
        send_spi();
        chk("R6", "no re-arm", dev_mode, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_commit_and_hold();
        t_abort();
        t_short_pulses();
        t_cmd_pin_high();
        t_init_left();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule